// File: doc/BRIEF.md
# NAND Flash Operation Trigger Engine

This block sits between a host register bus and an 8-bit NAND flash device and performs one elementary bus phase per software trigger. Software first loads a command byte, an address byte or a buffer select, then writes a one-hot code into the operation register. The engine drives the latch-enable, chip-enable and write/read strobes with a fixed clock-count pulse shape. It moves bytes between a banked internal buffer RAM and the flash data pins, and reports completion through a sticky done flag and an optional interrupt.

The engine tracks the flash ready/busy line itself. Page reads and status reads hold off the first read strobe until the device signals ready, and a reset command is only retired once the device is ready again. A full page larger than one buffer bank is moved by several triggers, one per bank, with software stepping the buffer select between them.

Top module: `nand_op_engine`

## Requirements
- R1: After reset, the operation register reads 0x0000 and the configuration register reads 0x0010. `fl_ce_n`, `fl_we_n` and `fl_re_n` are high, `fl_cle`, `fl_ale`, `fl_dq_oe` and `irq` are low.
- R2: Writing 0x0001 to the operation register (register 3) runs a command cycle. `fl_cle` is high and `fl_dq_out` carries the command byte (register 0) for one `fl_we_n` pulse that is low 2 clocks and then high 2 clocks.
- R3: Writing 0x0002 runs an address cycle. `fl_ale` is high and `fl_dq_out` carries the address byte (register 1) for one `fl_we_n` pulse of the same shape.
- R4: Writing 0x0004 runs a program transfer. The 512 bytes of the bank named by register 2 go out on `fl_dq_out` in ascending order, one per `fl_we_n` pulse, with `fl_cle` and `fl_ale` low.
- R5: Writing 0x0008 runs a page read. No `fl_re_n` pulse starts while `fl_rb` is low. Once `fl_rb` is high, 512 `fl_re_n` pulses follow. The byte on `fl_dq_in` at each `fl_re_n` rising edge is stored at ascending offsets of the selected bank.
- R6: Writing 0x0010 runs an ID read. It does not wait for `fl_rb` and stores 6 bytes at offsets 0 to 5 of the selected bank.
- R7: Writing 0x0020 runs a status read. It waits for `fl_rb` high and stores one byte at offset 0 of the selected bank. The rest of that bank and every other bank are left unchanged.
- R8: Bit 15 of the operation register (done) sets when any operation other than a reset command finishes. It stays set until a write to the operation register with bit 15 at 0; writing 1 never sets it. While an operation runs, its one-hot bit reads back as 1.
- R9: When a command cycle sends 0xFF, the engine waits for `fl_rb` high after the pulse. The whole operation register then reads 0x0000 and done stays clear.
- R10: A write to the operation register while an operation runs is ignored. It changes neither the running operation nor the done flag.
- R11: `irq` is high exactly when done is set and bit 4 (mask) of the configuration register (register 4) is clear.
- R12: An operation-register write whose bits 5:0 are zero or have more than one bit set starts nothing and drives no flash pin.

Host map: `hst_addr[11]`=0 addresses buffer RAM byte `bank*512+offset`. `hst_addr[11]`=1 addresses registers by `hst_addr[2:0]`. Read data appears on `hst_rdata` one clock after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_addr | input | 12 | Host address: RAM byte or register |
| hst_wr | input | 1 | Host write strobe |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, one clock after address |
| irq | output | 1 | Completion interrupt |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low |
| fl_dq_out | output | 8 | Data driven toward flash |
| fl_dq_oe | output | 1 | Output enable for fl_dq_out |
| fl_dq_in | input | 8 | Data from flash |
| fl_rb | input | 1 | Ready (1) / busy (0) from flash |

## Verification
The assertions assume that `fl_rb` is a clean synchronous level and that the host never writes a buffer byte that a running read operation is filling. They also assume the command byte is not rewritten while a command cycle is in flight. The stimulus follows these assumptions: every register and RAM write is issued while the engine is idle. The only writes made during an operation are operation-register writes aimed at checking that they are ignored. `fl_rb` is changed only on falling clock edges, from the bench's main sequence.

// File: rtl/nand_eng_pkg.sv
package nand_eng_pkg;
   typedef enum logic [2:0] {
      OP_CMD  = 3'd0,
      OP_ADDR = 3'd1,
      OP_DIN  = 3'd2,
      OP_PAGE = 3'd3,
      OP_ID   = 3'd4,
      OP_STAT = 3'd5
   } op_e;

   localparam int unsigned NUM_OPS  = 6;
   localparam int unsigned DONE_BIT = 15;
   localparam int unsigned MASK_BIT = 4;

   localparam logic [2:0] RA_CMD    = 3'd0;
   localparam logic [2:0] RA_ADDR   = 3'd1;
   localparam logic [2:0] RA_BUFSEL = 3'd2;
   localparam logic [2:0] RA_OPER   = 3'd3;
   localparam logic [2:0] RA_CFG    = 3'd4;
endpackage

// File: rtl/nand_eng_ram.sv
module nand_eng_ram #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 2048,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic [AW-1:0] h_addr,
   input  logic          h_we,
   input  logic [DW-1:0] h_wdata,
   output logic [DW-1:0] h_rdata,
   input  logic [AW-1:0] e_addr,
   input  logic          e_we,
   input  logic [DW-1:0] e_wdata,
   output logic [DW-1:0] e_rdata
);
   logic [DW-1:0] mem [DEPTH];

   // Engine writes win a same-address collision with the host port.
   always_ff @(posedge clk) begin
      if (h_we && !(e_we && e_addr == h_addr)) mem[h_addr] <= h_wdata;
      if (e_we) mem[e_addr] <= e_wdata;
      h_rdata <= mem[h_addr];
      e_rdata <= mem[e_addr];
   end
endmodule

// File: rtl/nand_eng_pulse.sv
module nand_eng_pulse #(
   parameter int unsigned LOW_CLKS  = 2,
   parameter int unsigned HIGH_CLKS = 2,
   localparam int unsigned PER      = LOW_CLKS + HIGH_CLKS,
   localparam int unsigned PW       = $clog2(PER)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic strobe_n,
   output logic rise,
   output logic last
);
   if (LOW_CLKS < 1 || HIGH_CLKS < 1) begin : g_bad_shape
      $error("strobe phases must each last at least one clock");
   end

   logic [PW-1:0] phase;

   assign last     = run && (phase == PW'(PER - 1));
   assign rise     = run && (phase == PW'(LOW_CLKS - 1));
   assign strobe_n = !(run && (phase < PW'(LOW_CLKS)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             phase <= '0;
      else if (!run || last)  phase <= '0;
      else                    phase <= phase + 1'b1;
   end

   a_r2_rise_in_low: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> ($past(strobe_n) == 1'b0));
endmodule

// File: rtl/nand_eng_seq.sv
module nand_eng_seq
   import nand_eng_pkg::*;
#(
   parameter int unsigned DW        = 8,
   parameter int unsigned BUF_BYTES = 512,
   parameter int unsigned NBUF      = 4,
   parameter int unsigned ID_BYTES  = 6,
   parameter int unsigned LOW_CLKS  = 2,
   parameter int unsigned HIGH_CLKS = 2,
   parameter logic [7:0]  RST_CMD   = 8'hFF,
   localparam int unsigned BUF_AW   = $clog2(BUF_BYTES),
   localparam int unsigned SEL_W    = (NBUF > 1) ? $clog2(NBUF) : 1,
   localparam int unsigned RAM_AW   = BUF_AW + ((NBUF > 1) ? $clog2(NBUF) : 0)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  op_e               start_op,
   input  logic [DW-1:0]     cmd_byte,
   input  logic [DW-1:0]     addr_byte,
   input  logic [SEL_W-1:0]  buf_sel,
   output logic              busy,
   output op_e               cur_op,
   output logic              fin_done,
   output logic [RAM_AW-1:0] ram_addr,
   output logic              ram_we,
   output logic [DW-1:0]     ram_wdata,
   input  logic [DW-1:0]     ram_rdata,
   output logic              fl_cle,
   output logic              fl_ale,
   output logic              fl_ce_n,
   output logic              fl_we_n,
   output logic              fl_re_n,
   output logic [DW-1:0]     fl_dq_out,
   output logic              fl_dq_oe,
   input  logic [DW-1:0]     fl_dq_in,
   input  logic              fl_rb
);
   if (ID_BYTES > BUF_BYTES) begin : g_bad_id
      $error("ID transfer longer than one buffer bank");
   end

   typedef enum logic [1:0] {S_IDLE, S_WAIT, S_XFER, S_RSTW} st_e;
   st_e              state;
   logic [BUF_AW-1:0] idx;
   logic [BUF_AW:0]   nbytes;
   logic              run, strobe_n, p_rise, p_last, last_byte, is_out, is_rst;

   nand_eng_pulse #(.LOW_CLKS(LOW_CLKS), .HIGH_CLKS(HIGH_CLKS)) u_pulse (
      .clk, .rst_n, .run, .strobe_n, .rise(p_rise), .last(p_last));

   always_comb begin
      case (cur_op)
         OP_DIN, OP_PAGE: nbytes = (BUF_AW+1)'(BUF_BYTES);
         OP_ID:           nbytes = (BUF_AW+1)'(ID_BYTES);
         default:         nbytes = (BUF_AW+1)'(1);
      endcase
   end

   assign run       = (state == S_XFER);
   assign busy      = (state != S_IDLE);
   assign is_out    = cur_op inside {OP_PAGE, OP_ID, OP_STAT};
   assign is_rst    = (cur_op == OP_CMD) && (cmd_byte == RST_CMD);
   assign last_byte = ({1'b0, idx} == nbytes - 1'b1);
   assign fin_done  = run && p_last && last_byte && !is_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         cur_op <= OP_CMD;
         idx    <= '0;
      end else begin
         case (state)
            S_IDLE: if (start) begin
               cur_op <= start_op;
               idx    <= '0;
               state  <= (start_op inside {OP_PAGE, OP_STAT}) ? S_WAIT : S_XFER;
            end
            S_WAIT: if (fl_rb) state <= S_XFER;
            S_XFER: if (p_last) begin
               if (last_byte) begin
                  idx   <= '0;
                  state <= is_rst ? S_RSTW : S_IDLE;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            S_RSTW: if (fl_rb) state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   if (NBUF > 1) begin : g_banked
      assign ram_addr = {buf_sel, idx};
   end else begin : g_single
      logic unused_sel;
      assign unused_sel = ^buf_sel;
      assign ram_addr   = idx;
   end

   assign ram_we    = run && p_rise && is_out;
   assign ram_wdata = fl_dq_in;

   assign fl_cle    = run && (cur_op == OP_CMD);
   assign fl_ale    = run && (cur_op == OP_ADDR);
   assign fl_ce_n   = !busy;
   assign fl_we_n   = is_out ? 1'b1 : strobe_n;
   assign fl_re_n   = is_out ? strobe_n : 1'b1;
   assign fl_dq_oe  = run && !is_out;
   assign fl_dq_out = (cur_op == OP_CMD)  ? cmd_byte :
                      (cur_op == OP_ADDR) ? addr_byte : ram_rdata;

   a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(!fl_we_n && !fl_re_n));
   a_r3_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_cle && fl_ale));
   a_r5_hold_for_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_WAIT && !fl_rb) |=> fl_re_n);
   a_r4_bus_turn: assert property (@(posedge clk) disable iff (!rst_n)
      fl_dq_oe |-> fl_re_n);
   a_r9_reset_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_RSTW && !fl_rb) |=> busy);
endmodule

// File: rtl/nand_op_engine.sv
module nand_op_engine
   import nand_eng_pkg::*;
#(
   parameter int unsigned BUF_BYTES = 512,
   parameter int unsigned NBUF      = 4,
   parameter int unsigned ID_BYTES  = 6,
   parameter int unsigned LOW_CLKS  = 2,
   parameter int unsigned HIGH_CLKS = 2,
   parameter logic [15:0] CFG_RESET = 16'h0010,
   localparam int unsigned DW       = 8,
   localparam int unsigned BUF_AW   = $clog2(BUF_BYTES),
   localparam int unsigned SEL_W    = (NBUF > 1) ? $clog2(NBUF) : 1,
   localparam int unsigned RAM_AW   = BUF_AW + ((NBUF > 1) ? $clog2(NBUF) : 0),
   localparam int unsigned HOST_AW  = RAM_AW + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [HOST_AW-1:0] hst_addr,
   input  logic               hst_wr,
   input  logic [15:0]        hst_wdata,
   output logic [15:0]        hst_rdata,
   output logic               irq,
   output logic               fl_cle,
   output logic               fl_ale,
   output logic               fl_ce_n,
   output logic               fl_we_n,
   output logic               fl_re_n,
   output logic [DW-1:0]      fl_dq_out,
   output logic               fl_dq_oe,
   input  logic [DW-1:0]      fl_dq_in,
   input  logic               fl_rb
);
   if ((1 << $clog2(NBUF)) != NBUF || (1 << BUF_AW) != BUF_BYTES || RAM_AW < 3)
   begin : g_bad_geom
      $error("bank count and bank size must be powers of two");
   end

   logic [DW-1:0]     cmd_q, addr_q;
   logic [SEL_W-1:0]  sel_q;
   logic [15:0]       cfg_q, rd_mux, rd_q;
   logic              done_q, reg_space_q;
   logic              reg_hit, op_wr, op_acc, start, busy, fin_done;
   op_e               start_op, cur_op;
   logic [2:0]        ra;
   logic [5:0]        op_bits;
   logic [RAM_AW-1:0] e_addr;
   logic              e_we;
   logic [DW-1:0]     e_wdata, e_rdata, h_rdata;

   assign ra      = hst_addr[2:0];
   assign reg_hit = hst_wr && hst_addr[HOST_AW-1];
   assign op_wr   = reg_hit && (ra == RA_OPER);
   assign op_acc  = op_wr && !busy;
   assign start   = op_acc && $onehot(hst_wdata[NUM_OPS-1:0]);

   always_comb begin
      start_op = OP_CMD;
      for (int i = 0; i < NUM_OPS; i++)
         if (hst_wdata[i]) start_op = op_e'(3'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         addr_q <= '0;
         sel_q  <= '0;
         cfg_q  <= CFG_RESET;
         done_q <= 1'b0;
      end else begin
         if (reg_hit && ra == RA_CMD)    cmd_q  <= hst_wdata[DW-1:0];
         if (reg_hit && ra == RA_ADDR)   addr_q <= hst_wdata[DW-1:0];
         if (reg_hit && ra == RA_BUFSEL) sel_q  <= hst_wdata[SEL_W-1:0];
         if (reg_hit && ra == RA_CFG)    cfg_q  <= hst_wdata;
         if (fin_done)    done_q <= 1'b1;
         else if (op_acc) done_q <= done_q & hst_wdata[DONE_BIT];
      end
   end

   assign op_bits = busy ? (6'b1 << cur_op) : 6'b0;
   assign irq     = done_q && !cfg_q[MASK_BIT];

   always_comb begin
      case (ra)
         RA_CMD:    rd_mux = 16'(cmd_q);
         RA_ADDR:   rd_mux = 16'(addr_q);
         RA_BUFSEL: rd_mux = 16'(sel_q);
         RA_OPER:   rd_mux = {done_q, 9'b0, op_bits};
         RA_CFG:    rd_mux = cfg_q;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q        <= '0;
         reg_space_q <= 1'b0;
      end else begin
         rd_q        <= rd_mux;
         reg_space_q <= hst_addr[HOST_AW-1];
      end
   end

   assign hst_rdata = reg_space_q ? rd_q : 16'(h_rdata);

   nand_eng_ram #(.DW(DW), .DEPTH(1 << RAM_AW)) u_ram (
      .clk,
      .h_addr (hst_addr[RAM_AW-1:0]),
      .h_we   (hst_wr && !hst_addr[HOST_AW-1]),
      .h_wdata(hst_wdata[DW-1:0]),
      .h_rdata,
      .e_addr, .e_we, .e_wdata, .e_rdata);

   nand_eng_seq #(
      .DW(DW), .BUF_BYTES(BUF_BYTES), .NBUF(NBUF), .ID_BYTES(ID_BYTES),
      .LOW_CLKS(LOW_CLKS), .HIGH_CLKS(HIGH_CLKS)
   ) u_seq (
      .clk, .rst_n, .start, .start_op,
      .cmd_byte(cmd_q), .addr_byte(addr_q), .buf_sel(sel_q),
      .busy, .cur_op, .fin_done,
      .ram_addr(e_addr), .ram_we(e_we), .ram_wdata(e_wdata), .ram_rdata(e_rdata),
      .fl_cle, .fl_ale, .fl_ce_n, .fl_we_n, .fl_re_n,
      .fl_dq_out, .fl_dq_oe, .fl_dq_in, .fl_rb);

   a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !(op_wr && !hst_wdata[DONE_BIT])) |=> done_q);
   a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_wr) |=> (cur_op == $past(cur_op)));
   a_r12_no_start_bad: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && op_wr && !$onehot(hst_wdata[NUM_OPS-1:0])) |=> !busy);
endmodule

// File: tb/nand_op_engine_bench.sv
module nand_op_engine_bench;
   localparam int CLK_P = 10;
   localparam logic [11:0] REGB = 12'h800;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic [11:0] hst_addr = '0;
   logic        hst_wr = 1'b0;
   logic [15:0] hst_wdata = '0, hst_rdata;
   logic        irq, fl_cle, fl_ale, fl_ce_n, fl_we_n, fl_re_n, fl_dq_oe;
   logic [7:0]  fl_dq_out, fl_dq_in = 8'h00;
   logic        fl_rb = 1'b1;

   int n_tests = 0, n_fail = 0, re_falls = 0, ce_falls = 0;
   bit finished = 0, we_seen = 0;
   time we_t0;
   logic [9:0] exp_we_q [$];
   logic [7:0] src_q [$];
   logic [7:0] rdexp_q [$];

   always #(CLK_P/2) clk = ~clk;

   nand_op_engine u_nand_op_engine (.*);

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic hwrite(input logic [11:0] a, input logic [15:0] d);
      @(negedge clk); hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
      @(negedge clk); hst_wr = 1'b0;
   endtask

   task automatic hread(input logic [11:0] a, output logic [15:0] d);
      @(negedge clk); hst_addr = a;
      @(negedge clk); d = hst_rdata;
   endtask

   task automatic wait_idle(output logic [15:0] v);
      for (int k = 0; k < 3000; k++) begin
         hread(REGB | 12'd3, v);
         if (v[5:0] == 6'd0) return;
      end
   endtask

   task automatic drain_buf(input int base, input int n, input string tag);
      logic [15:0] v;
      for (int i = 0; i < n; i++) begin
         hread(12'(base + i), v);
         chk(v[7:0] == rdexp_q[0], tag, v, rdexp_q[0]);
         void'(rdexp_q.pop_front());
      end
   endtask

   // Scoreboard monitor: every WE# rising edge must match the oldest expected item
   always @(negedge fl_we_n) begin we_t0 = $time; we_seen = 1; end
   always @(posedge fl_we_n) if (we_seen) begin
      we_seen = 0;
      chk(($time - we_t0) == 2*CLK_P, "R2 WE# low width", 32'($time - we_t0), 2*CLK_P);
      if (exp_we_q.size() == 0)
         chk(0, "R10/R12 unexpected WE# pulse", {fl_cle, fl_ale, fl_dq_out}, 0);
      else begin
         chk({fl_cle, fl_ale, fl_dq_out} == exp_we_q[0] && fl_dq_oe,
             "R2/R3/R4 WE# item", {fl_cle, fl_ale, fl_dq_out}, exp_we_q[0]);
         void'(exp_we_q.pop_front());
      end
   end
   // Flash read model: present next byte when RE# falls
   always @(negedge fl_re_n) begin
      re_falls++;
      if (src_q.size() != 0) fl_dq_in = src_q.pop_front();
      else fl_dq_in = 8'hEE;
   end
   always @(negedge fl_ce_n) ce_falls++;

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      int rf, cf;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      hread(REGB | 12'd3, v); chk(v == 16'h0000, "R1 op reg", v, 0);
      hread(REGB | 12'd4, v); chk(v == 16'h0010, "R1 cfg reg", v, 16'h10);
      chk({fl_ce_n, fl_we_n, fl_re_n, fl_cle, fl_ale, fl_dq_oe, irq} == 7'b1110000,
          "R1 idle pins", {fl_ce_n, fl_we_n, fl_re_n, fl_cle, fl_ale, fl_dq_oe, irq}, 7'b1110000);

      // R2 command cycle
      hwrite(REGB | 12'd0, 16'h0030);
      exp_we_q.push_back({2'b10, 8'h30});
      hwrite(REGB | 12'd3, 16'h0001);
      hread(REGB | 12'd3, v); chk(v == 16'h0001, "R8 running bit", v, 1);
      wait_idle(v); chk(v == 16'h8000, "R8 done after command", v, 16'h8000);

      // R11 / R8 interrupt and done clearing
      chk(irq == 1'b0, "R11 masked irq", irq, 0);
      hwrite(REGB | 12'd4, 16'h0000);
      chk(irq == 1'b1, "R11 unmasked irq", irq, 1);
      hwrite(REGB | 12'd3, 16'h8000);
      hread(REGB | 12'd3, v); chk(v == 16'h8000, "R8 writing 1 keeps done", v, 16'h8000);
      hwrite(REGB | 12'd3, 16'h0000);
      hread(REGB | 12'd3, v); chk(v == 16'h0000, "R8 done cleared", v, 0);
      chk(irq == 1'b0, "R11 irq drops", irq, 0);

      // R3 address cycle
      hwrite(REGB | 12'd1, 16'h005A);
      exp_we_q.push_back({2'b01, 8'h5A});
      hwrite(REGB | 12'd3, 16'h0002);
      wait_idle(v); chk(v == 16'h8000, "R3 address done", v, 16'h8000);

      // R4 program transfer from bank 2
      for (int i = 0; i < 512; i++) hwrite(12'(1024 + i), 16'((i*7 + 3) & 255));
      for (int i = 0; i < 512; i++) exp_we_q.push_back({2'b00, 8'((i*7 + 3) & 255)});
      hwrite(REGB | 12'd2, 16'd2);
      hwrite(REGB | 12'd3, 16'h0004);
      wait_idle(v); chk(v == 16'h8000, "R4 program done", v, 16'h8000);
      chk(exp_we_q.size() == 0, "R4 all bytes driven", exp_we_q.size(), 0);

      // R5 page read into bank 3, held off by busy
      fl_rb = 1'b0;
      for (int i = 0; i < 512; i++) begin
         src_q.push_back(8'((i*13 + 1) & 255));
         rdexp_q.push_back(8'((i*13 + 1) & 255));
      end
      hwrite(REGB | 12'd2, 16'd3);
      rf = re_falls;
      hwrite(REGB | 12'd3, 16'h0008);
      repeat (40) @(negedge clk);
      chk(re_falls == rf, "R5 no RE# while busy", re_falls - rf, 0);
      hread(REGB | 12'd3, v); chk(v == 16'h0008, "R5 waiting op reads running", v, 8);
      fl_rb = 1'b1;
      wait_idle(v); chk(v == 16'h8000, "R5 page done", v, 16'h8000);
      chk(re_falls - rf == 512, "R5 pulse count", re_falls - rf, 512);
      drain_buf(1536, 512, "R5 page byte");

      // R7 status into bank 1, bank 0 and rest of bank 1 intact
      hwrite(12'd0, 16'h00A5);
      hwrite(12'd513, 16'h003C);
      fl_rb = 1'b0;
      src_q.push_back(8'hC1);
      hwrite(REGB | 12'd2, 16'd1);
      rf = re_falls;
      hwrite(REGB | 12'd3, 16'h0020);
      repeat (20) @(negedge clk);
      chk(re_falls == rf, "R7 status waits for ready", re_falls - rf, 0);
      fl_rb = 1'b1;
      wait_idle(v); chk(v == 16'h8000, "R7 status done", v, 16'h8000);
      rdexp_q.push_back(8'hC1); drain_buf(512, 1, "R7 status byte");
      rdexp_q.push_back(8'h3C); drain_buf(513, 1, "R7 neighbour untouched");
      rdexp_q.push_back(8'hA5); drain_buf(0, 1, "R7 bank 0 untouched");

      // R6 ID read into bank 0 without waiting for ready
      fl_rb = 1'b0;
      for (int i = 0; i < 6; i++) begin
         src_q.push_back(8'(8'h90 + i));
         rdexp_q.push_back(8'(8'h90 + i));
      end
      hwrite(REGB | 12'd2, 16'd0);
      hwrite(REGB | 12'd3, 16'h0010);
      wait_idle(v); chk(v == 16'h8000, "R6 ID done while busy", v, 16'h8000);
      drain_buf(0, 6, "R6 ID byte");

      // R10 write during a running operation is ignored
      for (int i = 0; i < 512; i++) src_q.push_back(8'(i));
      hwrite(REGB | 12'd3, 16'h0008);
      hwrite(REGB | 12'd3, 16'h0001);
      hread(REGB | 12'd3, v); chk(v == 16'h0008, "R10 op unchanged", v, 8);
      fl_rb = 1'b1;
      wait_idle(v); chk(v == 16'h8000, "R10 original op completes", v, 16'h8000);
      hwrite(REGB | 12'd3, 16'h0000);

      // R12 malformed codes start nothing
      cf = ce_falls;
      hwrite(REGB | 12'd3, 16'h0003);
      repeat (10) @(negedge clk);
      hread(REGB | 12'd3, v); chk(v == 16'h0000, "R12 two bits set", v, 0);
      hwrite(REGB | 12'd3, 16'h0000);
      repeat (10) @(negedge clk);
      chk(ce_falls == cf, "R12 no chip enable", ce_falls - cf, 0);

      // R9 reset command completes when whole register reads zero
      fl_rb = 1'b0;
      hwrite(REGB | 12'd0, 16'h00FF);
      exp_we_q.push_back({2'b10, 8'hFF});
      hwrite(REGB | 12'd3, 16'h0001);
      repeat (30) @(negedge clk);
      hread(REGB | 12'd3, v); chk(v == 16'h0001, "R9 held while busy", v, 1);
      fl_rb = 1'b1;
      repeat (3) @(negedge clk);
      hread(REGB | 12'd3, v); chk(v == 16'h0000, "R9 register reads zero", v, 0);
      chk(irq == 1'b0, "R9 no done interrupt", irq, 0);
      chk(exp_we_q.size() == 0, "R2 every expected pulse seen", exp_we_q.size(), 0);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule